// File: doc/BRIEF.md
# Pad Pull Configuration Register Bank

This block stores the bias setting of every pad in a group of GPIO banks and presents all of them at once on a flat output vector that feeds the pad bias controls. Software reaches the settings through a 32-bit, word-addressed read/write port. Each pad takes a two-bit code, so one register word carries eight pads in its low half. The high half of a write word is a per-bit enable for the low half, which lets software change one pad without a read-modify-write.

Two address regions exist. The main region serves every bank at a fixed stride. It begins one word below its nominal base, and it places pins in descending order within a word. A small separate region serves the lowest pins of bank 0 in ascending order. Those pins cannot be reached through the main region.

Top module: `pad_pull_regs`

## Requirements
- R1: Each pad holds a 2-bit code: 0 no pull, 1 pull-up, 2 pull-down, 3 bus-hold. Pad p = bank*PINS_PER_BANK + pin drives padPull[2p+1:2p].
- R2: In the main region, pins 8r to 8r+7 of bank b sit at word address MAIN_BASE - 1 + BANK_STRIDE*b + r (defaults: MAIN_BASE=16, BANK_STRIDE=4, four banks of 32 pins, so words 15 to 30).
- R3: Main-region words use descending order: pin 8r+k occupies bits 2(7-k)+1:2(7-k). Pin 8r is in bits 15:14 and pin 8r+7 is in bits 1:0.
- R4: On a write, data bit n (n<16) is updated only when bit n+16 is set. A bit whose enable is clear keeps its value, and an all-zero enable half changes nothing.
- R5: Bank 0 pins 0 to SPLIT_PINS-1 (default 12) live in the separate region. Pin k is at word SPLIT_BASE + k/8 (default 64) in bits 2(k%8)+1:2(k%8), in ascending order.
- R6: Bank 0 pins below SPLIT_PINS are not reachable in the main region. Main word MAIN_BASE-1 is unmapped. In word MAIN_BASE, the lanes for pins 8 to 11 (bits 15:8) read zero and ignore writes.
- R7: A read returns on rdData the cycle after rdEn is high, with bits 31:16 zero. When rdEn was low, rdData is zero.
- R8: A write to an unmapped address changes no pad, and a read from one returns zero. Unused lanes of split word 65 (bits 15:8) read zero.
- R9: A write shows on padPull from the clock edge that ends the write cycle. A read in the same cycle as a write to that word returns the old contents.
- R10: After reset every pad code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Word address |
| wrEn | input | 1 | Write strobe for this cycle |
| rdEn | input | 1 | Read strobe for this cycle |
| wrData | input | 32 | Write word: enables in 31:16, data in 15:0 |
| rdData | output | 32 | Registered read word |
| padPull | output | 2*NUM_BANKS*PINS_PER_BANK | Pull code of every pad |

## Verification
The timing contract is fixed. A write shows on padPull at the rising edge that closes the write cycle. Read data appears after that same edge and stays there for exactly one cycle. The bench drives all strobes on falling edges and holds them for one cycle. It compares padPull on the next falling edge. A monitor notes each rising edge at which rdEn was high and compares rdData, popped from the expectation queue, at the falling edge that follows. Same-cycle read and write therefore expect the pre-write word.

// File: rtl/pad_pull_pkg.sv
package pad_pull_pkg;
  localparam int FIELD_W = 8;
  localparam int CODE_W  = 2;
  localparam int LANES   = 8;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_UP   = 2'd1,
    PULL_DOWN = 2'd2,
    PULL_HOLD = 2'd3
  } pullCode_e;

  typedef struct packed {
    logic               mainSel;
    logic               splitSel;
    logic               doWrite;
    logic               doRead;
    logic [FIELD_W-1:0] bankIdx;
    logic [FIELD_W-1:0] regIdx;
  } pullStrobe_t;
endpackage

// File: rtl/pad_pull_decode.sv
module pad_pull_decode
  import pad_pull_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int SPLIT_PINS    = 12,
  parameter int ADDR_W        = 8,
  parameter int MAIN_BASE     = 16,
  parameter int BANK_STRIDE   = 4,
  parameter int SPLIT_BASE    = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output pullStrobe_t       strobe
);
  localparam int REGS_PER_BANK = PINS_PER_BANK / LANES;
  localparam int MAIN_START    = MAIN_BASE - 1;
  localparam int MAIN_WORDS    = NUM_BANKS * BANK_STRIDE;
  localparam int SPLIT_WORDS   = (SPLIT_PINS + LANES - 1) / LANES;
  localparam int SPLIT_FULL    = SPLIT_PINS / LANES;

  int mainOff;
  int splitOff;
  int bankN;
  int regN;

  always_comb begin
    mainOff  = int'(addr) - MAIN_START;
    splitOff = int'(addr) - SPLIT_BASE;
    bankN    = (mainOff >= 0) ? mainOff / BANK_STRIDE : 0;
    regN     = (mainOff >= 0) ? mainOff % BANK_STRIDE : 0;
    strobe   = '0;
    if (mainOff >= 0 && mainOff < MAIN_WORDS && regN < REGS_PER_BANK &&
        !(bankN == 0 && regN < SPLIT_FULL)) begin
      strobe.mainSel = 1'b1;
      strobe.bankIdx = FIELD_W'(bankN);
      strobe.regIdx  = FIELD_W'(regN);
    end else if (splitOff >= 0 && splitOff < SPLIT_WORDS) begin
      strobe.splitSel = 1'b1;
      strobe.regIdx   = FIELD_W'(splitOff);
    end
    strobe.doWrite = wrEn;
    strobe.doRead  = rdEn;
  end
endmodule

// File: rtl/pad_pull_store.sv
module pad_pull_store
  import pad_pull_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int SPLIT_PINS    = 12,
  localparam int NUM_PADS     = NUM_BANKS * PINS_PER_BANK
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pullStrobe_t                strobe,
  input  logic [31:0]                wrData,
  output logic [31:0]                rdData,
  output logic [CODE_W*NUM_PADS-1:0] padPull
);
  localparam int HALF = 16;

  logic [HALF-1:0] laneWord [NUM_PADS];
  logic [HALF-1:0] rdWord;

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int  BANK     = p / PINS_PER_BANK;
    localparam int  PIN      = p % PINS_PER_BANK;
    localparam bit  IN_SPLIT = (BANK == 0) && (PIN < SPLIT_PINS);
    localparam int  REG      = PIN / LANES;
    localparam int  POS      = IN_SPLIT ? CODE_W * (PIN % LANES)
                                        : CODE_W * (LANES - 1 - (PIN % LANES));
    logic              hit;
    logic [CODE_W-1:0] padCode;

    assign hit = IN_SPLIT
      ? (strobe.splitSel && int'(strobe.regIdx) == REG)
      : (strobe.mainSel && int'(strobe.bankIdx) == BANK && int'(strobe.regIdx) == REG);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        padCode <= PULL_NONE;
      end else if (strobe.doWrite && hit) begin
        for (int i = 0; i < CODE_W; i++) begin
          if (wrData[POS + i + HALF]) padCode[i] <= wrData[POS + i];
        end
      end
    end

    assign padPull[CODE_W*p +: CODE_W] = padCode;
    assign laneWord[p] = hit ? (HALF'(padCode) << POS) : '0;
  end

  always_comb begin
    rdWord = '0;
    for (int p = 0; p < NUM_PADS; p++) rdWord = rdWord | laneWord[p];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= strobe.doRead ? {{HALF{1'b0}}, rdWord} : '0;
  end
endmodule

// File: rtl/pad_pull_regs.sv
module pad_pull_regs
  import pad_pull_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int PINS_PER_BANK = 32,
  parameter int SPLIT_PINS    = 12,
  parameter int ADDR_W        = 8,
  parameter int MAIN_BASE     = 16,
  parameter int BANK_STRIDE   = 4,
  parameter int SPLIT_BASE    = 64,
  localparam int PULL_W       = CODE_W * NUM_BANKS * PINS_PER_BANK
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [PULL_W-1:0] padPull
);
  pullStrobe_t ctlStrobe;

  pad_pull_decode #(
    .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK), .SPLIT_PINS(SPLIT_PINS),
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .BANK_STRIDE(BANK_STRIDE),
    .SPLIT_BASE(SPLIT_BASE)
  ) i_decode (
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .strobe(ctlStrobe)
  );

  pad_pull_store #(
    .NUM_BANKS(NUM_BANKS), .PINS_PER_BANK(PINS_PER_BANK), .SPLIT_PINS(SPLIT_PINS)
  ) i_store (
    .clk(clk), .rstN(rstN), .strobe(ctlStrobe), .wrData(wrData),
    .rdData(rdData), .padPull(padPull)
  );
endmodule

// File: rtl/pad_pull_checker.sv
module pad_pull_checker
  import pad_pull_pkg::*;
#(
  parameter int PULL_W = 256
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic              rdEn,
  input logic [31:0]       wrData,
  input logic [31:0]       rdData,
  input logic [PULL_W-1:0] padPull,
  input pullStrobe_t       ctlStrobe
);
  logic mapped;
  assign mapped = ctlStrobe.mainSel || ctlStrobe.splitSel;

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:16] == 16'h0); // R7
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> rdData == 32'h0); // R7
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !mapped |=> rdData == 32'h0); // R8
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !mapped |=> $stable(padPull)); // R8
  AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> $stable(padPull)); // R9
  AST_EMPTY_MASK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[31:16] == 16'h0 |=> $stable(padPull)); // R4
endmodule

bind pad_pull_regs pad_pull_checker #(.PULL_W(PULL_W)) i_checker (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData),
  .rdData(rdData), .padPull(padPull), .ctlStrobe(ctlStrobe)
);

// File: tb/test_pad_pull_regs.sv
`timescale 1ns/1ps
module test_pad_pull_regs;
  localparam int NB = 4, PPB = 32, SPL = 12, NPADS = NB * PPB;
  localparam int PW = 2 * NPADS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    addr = '0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [PW-1:0] padPull;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] exp; string tag; } rdItem_t;
  rdItem_t rdQ[$];
  logic [1:0] model [NPADS];

  pad_pull_regs i_pad_pull_regs (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .padPull(padPull)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, logic [PW-1:0] act, logic [PW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // pad index for lane of a word address, -1 when not mapped
  function automatic int mapPad(int a, int lane);
    int off, b, r, pin;
    if (a >= 15 && a <= 30) begin
      off = a - 15; b = off / 4; r = off % 4; pin = 8 * r + (7 - lane);
      if (b == 0 && pin < SPL) return -1;
      return b * PPB + pin;
    end
    if (a == 64 || a == 65) begin
      pin = 8 * (a - 64) + lane;
      if (pin >= SPL) return -1;
      return pin;
    end
    return -1;
  endfunction

  function automatic logic [31:0] modelRead(int a);
    logic [31:0] w = '0;
    for (int l = 0; l < 8; l++) begin
      int pd = mapPad(a, l);
      if (pd >= 0) w[2*l +: 2] = model[pd];
    end
    return w;
  endfunction

  function automatic logic [PW-1:0] modelVec();
    logic [PW-1:0] v;
    for (int p = 0; p < NPADS; p++) v[2*p +: 2] = model[p];
    return v;
  endfunction

  task automatic modelWrite(int a, logic [31:0] d);
    for (int l = 0; l < 8; l++) begin
      int pd = mapPad(a, l);
      if (pd >= 0)
        for (int i = 0; i < 2; i++)
          if (d[2*l + i + 16]) model[pd][i] = d[2*l + i];
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic access(bit wr, bit rd, int a, logic [31:0] d, string tag);
    rdItem_t it;
    addr = 8'(a); wrEn = wr; rdEn = rd; wrData = d;
    if (rd) begin it.exp = modelRead(a); it.tag = tag; rdQ.push_back(it); end
    if (wr) modelWrite(a, d);
    @(negedge clk);
    wrEn = 1'b0; rdEn = 1'b0;
    if (wr) chk({tag, " padPull"}, padPull, modelVec());
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      if (rdEn === 1'b1) begin
        rdItem_t it;
        @(negedge clk);
        if (rdQ.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7 unexpected read actual=%h expected=none", rdData);
        end else begin
          it = rdQ.pop_front();
          chk({it.tag, " rdData"}, PW'(rdData), PW'(it.exp));
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    for (int p = 0; p < NPADS; p++) model[p] = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R10 reset pads", padPull, '0);
    access(0, 1, 19, 0, "R10 reset read");
    access(0, 1, 64, 0, "R10 reset split read");

    // R2 R3: bits 15:14 of bank1 reg0 are pin 0 of bank 1 (pad 32)
    access(1, 0, 19, 32'hC000_4000, "R3 lowest pin top lane");
    chk("R3 pad32 pull-up", PW'(padPull[65:64]), PW'(2'b01));
    chk("R3 pad39 untouched", PW'(padPull[79:78]), PW'(2'b00));

    // R1: all four codes
    access(1, 0, 20, 32'hFFFF_E4E4, "R1 codes");
    chk("R1 pad40 bus-hold", PW'(padPull[81:80]), PW'(2'b11));
    chk("R1 pad41 pull-down", PW'(padPull[83:82]), PW'(2'b10));
    access(0, 1, 20, 0, "R1 readback");

    // R4: masked writes
    access(1, 0, 20, 32'h0003_0001, "R4 low lane only");
    access(1, 0, 20, 32'h00F0_0000, "R4 clear two lanes");
    access(1, 0, 20, 32'h0000_FFFF, "R4 empty mask");
    access(1, 0, 20, 32'h0001_0000, "R4 single bit clear");
    access(0, 1, 20, 0, "R4 readback");

    // R2: every mapped main word
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < 4; r++)
        access(1, 0, 15 + 4*b + r, {16'hFFFF, 16'((4*b + r + 1) * 16'h1357)}, "R2 fill");
    for (int a = 15; a <= 30; a++) access(0, 1, a, 0, "R2 readback");

    // R5: split region ascending
    access(1, 0, 64, 32'h000C_0008, "R5 pin1");
    chk("R5 pad1 pull-down", PW'(padPull[3:2]), PW'(2'b10));
    access(1, 0, 65, 32'hFFFF_FFFF, "R5 word1");
    chk("R5 pads 8..11 bus-hold", PW'(padPull[23:16]), PW'(8'hFF));
    access(0, 1, 65, 0, "R5 R8 word1 readback");
    access(0, 1, 64, 0, "R5 word0 readback");

    // R6: bank0 low pins hidden in main region
    access(1, 0, 65, 32'hFFFF_0000, "R6 clear pins 8..11");
    access(1, 0, 16, 32'hFFFF_FFFF, "R6 main word bank0");
    chk("R6 pads 8..11 unchanged", PW'(padPull[23:16]), PW'(8'h00));
    chk("R6 pads 12..15 set", PW'(padPull[31:24]), PW'(8'hFF));
    access(0, 1, 16, 0, "R6 readback");
    access(1, 1, 15, 32'hFFFF_FFFF, "R6 word below base");

    // R8: unmapped
    access(1, 1, 31, 32'hFFFF_FFFF, "R8 above main");
    access(1, 1, 66, 32'hFFFF_FFFF, "R8 above split");
    access(1, 1, 0, 32'hFFFF_FFFF, "R8 zero addr");
    access(1, 1, 255, 32'hFFFF_FFFF, "R8 top addr");

    // R9: read and write same word in one cycle
    access(1, 1, 21, 32'hFFFF_A5A5, "R9 same-cycle old value");
    access(0, 1, 21, 0, "R9 new value");

    // R7: idle read port
    @(negedge clk);
    chk("R7 idle rdData", PW'(rdData), '0);
    access(0, 1, 28, 0, "R7 read");
    @(negedge clk);
    chk("R7 rdData clears", PW'(rdData), '0);

    repeat (3) @(negedge clk);
    if (rdQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 pending reads actual=%0d expected=0", rdQ.size());
    end
    finishRun();
  end
endmodule